// File: doc/BRIEF.md
# Network Controller Command Decoder

This block takes the 8-bit commands that a host writes to the command register of a token-passing network controller and keeps the controller's transmit and receive control state. It decodes each write into one of four actions: arm a transmission, arm reception, cancel a transmission, or cancel reception. It holds the transmitter-available, transmit-acknowledged and receiver-inhibited status flags. It also latches the buffer start address chosen for each direction and whether broadcast packets are accepted.

Arming and status clears take effect at once. A transmission and both cancels wait for the next token strobe from the packet engine. The engine reports progress through several inputs: a receive-in-progress level, a reception-complete strobe, a transmit-complete strobe and an ACK-received strobe. Buffer start addresses are given as one of four pages plus an optional half-page offset inside a 2 KiB buffer.

Top module: `netcmd_ctrl`

## Requirements
- R1: After reset, tx_avail = 1, tx_acked = 0, rx_inhib = 1, rx_en = 0, rx_bcast = 0, tx_req = 0 and both base addresses are 0.
- R2: A write of a code matching 00xx_x011 clears tx_avail and tx_acked and latches tx_base in the cycle after the write. tx_req stays 0 until a token strobe arrives, and goes to 1 in the cycle after that token.
- R3: While tx_req = 1, a tx_done strobe returns tx_req to 0 and sets tx_avail to 1. tx_acked is then 1 exactly when an ack_in strobe arrived while tx_req was 1.
- R4: A write of 0000_0001 while a transmission is armed but not started changes nothing until the next token. At that token the armed transmission is dropped (tx_req stays 0) and tx_avail becomes 1.
- R5: A write of a code matching x0xx_x100 sets rx_en to 1, clears rx_inhib to 0, latches rx_base, and sets rx_bcast to bit 7 of the code, all in the cycle after the write.
- R6: While rx_en = 1, an rx_done strobe sets rx_inhib to 1 and rx_en to 0.
- R7: A write of 0000_0010 changes nothing until the next token. If rx_active is 0 at that token, rx_inhib becomes 1 and rx_en becomes 0.
- R8: After a 0000_0010 write, a token that arrives while rx_active = 1 leaves rx_en at 1. The reception ends through rx_done as usual.
- R9: The base address is taken from the command. Bits 4:3 of the code select the page and bit 5 selects the half page, giving base = page × 512 + half × 256.
- R10: Code 0000_0000 (kept for command chaining) and every code matching none of the formats above change no output, either at the write or at the following token.
- R11: A 0000_0001 write made after a transmission has started (tx_req = 1) has no effect. tx_req stays 1 through later tokens until tx_done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Command register write strobe |
| host_data | input | 8 | Command code written |
| token_in | input | 1 | Token received strobe |
| rx_active | input | 1 | A packet reception is in progress |
| rx_done | input | 1 | Packet received successfully |
| tx_done | input | 1 | Transmit sequence finished |
| ack_in | input | 1 | ACK received from destination |
| tx_avail | output | 1 | Transmitter-available status |
| tx_acked | output | 1 | Transmit-acknowledged status |
| rx_inhib | output | 1 | Receiver-inhibited status |
| tx_req | output | 1 | Transmission in progress, request to engine |
| tx_base | output | ADDR_W | Transmit buffer start address |
| rx_en | output | 1 | Reception enabled |
| rx_base | output | ADDR_W | Receive buffer start address |
| rx_bcast | output | 1 | Broadcast packets accepted |

## Verification
Every output is a register, so a write, token or completion strobe that is applied at one clock edge shows up at the outputs right after that edge, one cycle later. No result is due later than that. The bench drives each stimulus for exactly one cycle between falling edges and samples on the next falling edge. It therefore always reads the state one edge after the stimulus. For R4, R7 and R8 it also samples between the write and the token, which shows that the cancels wait for the token. All 256 command codes are swept, each from reset, and the outputs are checked after the write and again after a token.

// File: rtl/netcmd_pkg.sv
package netcmd_pkg;

    typedef enum logic [2:0] {
        OP_NONE   = 3'd0,
        OP_TX_OFF = 3'd1,
        OP_RX_OFF = 3'd2,
        OP_TX_ON  = 3'd3,
        OP_RX_ON  = 3'd4
    } op_e;

    typedef struct packed {
        op_e        op;
        logic       bcast;
        logic       half;
        logic [1:0] page;
    } cmd_t;

    localparam logic [7:0] CODE_TX_OFF = 8'h01;
    localparam logic [7:0] CODE_RX_OFF = 8'h02;
    localparam logic [2:0] TAG_TX_ON   = 3'b011;
    localparam logic [2:0] TAG_RX_ON   = 3'b100;

    function automatic cmd_t decode_cmd(input logic [7:0] code);
        cmd_t c;
        c.op    = OP_NONE;
        c.bcast = code[7];
        c.half  = code[5];
        c.page  = code[4:3];
        if (code == CODE_TX_OFF)
            c.op = OP_TX_OFF;
        else if (code == CODE_RX_OFF)
            c.op = OP_RX_OFF;
        else if (code[7:6] == 2'b00 && code[2:0] == TAG_TX_ON)
            c.op = OP_TX_ON;
        else if (code[6] == 1'b0 && code[2:0] == TAG_RX_ON)
            c.op = OP_RX_ON;
        return c;
    endfunction

endpackage

// File: rtl/netcmd_decode.sv
module netcmd_decode
    import netcmd_pkg::*;
#(
    parameter int ADDR_W     = 11,
    parameter int PAGE_SHIFT = 9
) (
    input  logic              wr,
    input  logic [7:0]        data,
    output op_e               op,
    output logic              bcast,
    output logic [ADDR_W-1:0] base
);
    cmd_t cmd;

    always_comb begin
        cmd   = decode_cmd(data);
        op    = wr ? cmd.op : OP_NONE;
        bcast = cmd.bcast;
        base  = (ADDR_W'(cmd.page) << PAGE_SHIFT)
              | (ADDR_W'(cmd.half) << (PAGE_SHIFT - 1));
    end
endmodule

// File: rtl/netcmd_tx_ctl.sv
module netcmd_tx_ctl
    import netcmd_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  op_e               op,
    input  logic [ADDR_W-1:0] base_in,
    input  logic              token_in,
    input  logic              tx_done,
    input  logic              ack_in,
    output logic              tx_avail,
    output logic              tx_acked,
    output logic              tx_req,
    output logic [ADDR_W-1:0] tx_base
);
    logic armed;
    logic cancel;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed    <= 1'b0;
            cancel   <= 1'b0;
            tx_req   <= 1'b0;
            tx_avail <= 1'b1;
            tx_acked <= 1'b0;
            tx_base  <= '0;
        end else begin
            // token events first; a command in the same cycle overrides
            if (token_in) begin
                if (cancel) begin
                    armed  <= 1'b0;
                    cancel <= 1'b0;
                    if (!tx_req)
                        tx_avail <= 1'b1;
                end else if (armed) begin
                    armed  <= 1'b0;
                    tx_req <= 1'b1;
                end
            end
            if (tx_req && ack_in)
                tx_acked <= 1'b1;
            if (tx_req && tx_done) begin
                tx_req   <= 1'b0;
                tx_avail <= 1'b1;
            end
            case (op)
                OP_TX_ON: begin
                    armed    <= 1'b1;
                    cancel   <= 1'b0;
                    tx_avail <= 1'b0;
                    tx_acked <= 1'b0;
                    tx_base  <= base_in;
                end
                OP_TX_OFF: cancel <= 1'b1;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/netcmd_rx_ctl.sv
module netcmd_rx_ctl
    import netcmd_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  op_e               op,
    input  logic              bcast_in,
    input  logic [ADDR_W-1:0] base_in,
    input  logic              token_in,
    input  logic              rx_active,
    input  logic              rx_done,
    output logic              rx_inhib,
    output logic              rx_en,
    output logic              rx_bcast,
    output logic [ADDR_W-1:0] rx_base
);
    logic cancel;

    always_ff @(posedge clk) begin
        if (rst) begin
            cancel   <= 1'b0;
            rx_inhib <= 1'b1;
            rx_bcast <= 1'b0;
            rx_base  <= '0;
        end else begin
            if (rx_done && !rx_inhib) begin
                rx_inhib <= 1'b1;
                cancel   <= 1'b0;
            end
            // a cancel waits for a token seen while nothing is arriving
            if (token_in && cancel && !rx_active) begin
                rx_inhib <= 1'b1;
                cancel   <= 1'b0;
            end
            case (op)
                OP_RX_ON: begin
                    rx_inhib <= 1'b0;
                    cancel   <= 1'b0;
                    rx_bcast <= bcast_in;
                    rx_base  <= base_in;
                end
                OP_RX_OFF: cancel <= 1'b1;
                default: ;
            endcase
        end
    end

    assign rx_en = ~rx_inhib;
endmodule

// File: rtl/netcmd_ctrl.sv
module netcmd_ctrl
    import netcmd_pkg::*;
#(
    parameter int BUF_BYTES = 2048,
    parameter int PAGES     = 4,
    parameter int ADDR_W    = $clog2(BUF_BYTES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_wr,
    input  logic [7:0]        host_data,
    input  logic              token_in,
    input  logic              rx_active,
    input  logic              rx_done,
    input  logic              tx_done,
    input  logic              ack_in,
    output logic              tx_avail,
    output logic              tx_acked,
    output logic              rx_inhib,
    output logic              tx_req,
    output logic [ADDR_W-1:0] tx_base,
    output logic              rx_en,
    output logic [ADDR_W-1:0] rx_base,
    output logic              rx_bcast
);
    localparam int PAGE_SHIFT = $clog2(BUF_BYTES / PAGES);

    op_e               op;
    logic              bcast;
    logic [ADDR_W-1:0] base;

    netcmd_decode #(.ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT)) u_dec (
        .wr    (host_wr),
        .data  (host_data),
        .op    (op),
        .bcast (bcast),
        .base  (base)
    );

    netcmd_tx_ctl #(.ADDR_W(ADDR_W)) u_tx (
        .clk      (clk),
        .rst      (rst),
        .op       (op),
        .base_in  (base),
        .token_in (token_in),
        .tx_done  (tx_done),
        .ack_in   (ack_in),
        .tx_avail (tx_avail),
        .tx_acked (tx_acked),
        .tx_req   (tx_req),
        .tx_base  (tx_base)
    );

    netcmd_rx_ctl #(.ADDR_W(ADDR_W)) u_rx (
        .clk       (clk),
        .rst       (rst),
        .op        (op),
        .bcast_in  (bcast),
        .base_in   (base),
        .token_in  (token_in),
        .rx_active (rx_active),
        .rx_done   (rx_done),
        .rx_inhib  (rx_inhib),
        .rx_en     (rx_en),
        .rx_bcast  (rx_bcast),
        .rx_base   (rx_base)
    );
endmodule

// File: rtl/netcmd_ctrl_chk.sv
module netcmd_ctrl_chk #(
    parameter int ADDR_W = 11
) (
    input logic              clk,
    input logic              rst,
    input logic              host_wr,
    input logic [7:0]        host_data,
    input logic              token_in,
    input logic              rx_active,
    input logic              rx_done,
    input logic              tx_done,
    input logic              ack_in,
    input logic              tx_avail,
    input logic              tx_acked,
    input logic              rx_inhib,
    input logic              tx_req,
    input logic [ADDR_W-1:0] tx_base,
    input logic              rx_en,
    input logic [ADDR_W-1:0] rx_base,
    input logic              rx_bcast
);
    logic quiet;
    assign quiet = !token_in && !tx_done && !rx_done && !ack_in;

    assert_txon_clears_R2: assert property (@(posedge clk) disable iff (rst)
        host_wr && host_data[7:6] == 2'b00 && host_data[2:0] == 3'b011
        |=> !tx_avail && !tx_acked);

    assert_req_needs_token_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_req) |-> $past(token_in));

    assert_done_frees_R3: assert property (@(posedge clk) disable iff (rst)
        tx_req && tx_done && !host_wr |=> tx_avail && !tx_req);

    assert_busy_not_avail_R3: assert property (@(posedge clk) disable iff (rst)
        tx_req |-> !tx_avail);

    assert_rxon_enables_R5: assert property (@(posedge clk) disable iff (rst)
        host_wr && host_data[6] == 1'b0 && host_data[2:0] == 3'b100
        |=> rx_en && !rx_inhib);

    assert_rxdone_inhibits_R6: assert property (@(posedge clk) disable iff (rst)
        rx_en && rx_done && !host_wr |=> rx_inhib && !rx_en);

    assert_active_rx_kept_R8: assert property (@(posedge clk) disable iff (rst)
        rx_en && rx_active && !rx_done && !host_wr |=> rx_en);

    assert_reserved_ignored_R10: assert property (@(posedge clk) disable iff (rst)
        host_wr && host_data == 8'h00 && quiet
        |=> $stable(tx_avail) && $stable(tx_acked) && $stable(rx_inhib)
            && $stable(tx_req) && $stable(tx_base) && $stable(rx_base)
            && $stable(rx_bcast));
endmodule

bind netcmd_ctrl netcmd_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .host_wr   (host_wr),
    .host_data (host_data),
    .token_in  (token_in),
    .rx_active (rx_active),
    .rx_done   (rx_done),
    .tx_done   (tx_done),
    .ack_in    (ack_in),
    .tx_avail  (tx_avail),
    .tx_acked  (tx_acked),
    .rx_inhib  (rx_inhib),
    .tx_req    (tx_req),
    .tx_base   (tx_base),
    .rx_en     (rx_en),
    .rx_base   (rx_base),
    .rx_bcast  (rx_bcast)
);

// File: tb/netcmd_ctrl_test.sv
`timescale 1ns/1ps
module netcmd_ctrl_test;
    localparam int AW = 11;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic host_wr = 1'b0;
    logic [7:0] host_data = 8'h00;
    logic token_in = 1'b0, rx_active = 1'b0, rx_done = 1'b0;
    logic tx_done = 1'b0, ack_in = 1'b0;
    logic tx_avail, tx_acked, rx_inhib, tx_req, rx_en, rx_bcast;
    logic [AW-1:0] tx_base, rx_base;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    netcmd_ctrl uut (
        .clk(clk), .rst(rst), .host_wr(host_wr), .host_data(host_data),
        .token_in(token_in), .rx_active(rx_active), .rx_done(rx_done),
        .tx_done(tx_done), .ack_in(ack_in), .tx_avail(tx_avail),
        .tx_acked(tx_acked), .rx_inhib(rx_inhib), .tx_req(tx_req),
        .tx_base(tx_base), .rx_en(rx_en), .rx_base(rx_base),
        .rx_bcast(rx_bcast)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000 && !done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d cycles, expected completion", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wrc(input logic [7:0] code);
        @(negedge clk);
        host_wr = 1'b1;
        host_data = code;
        @(negedge clk);
        host_wr = 1'b0;
        host_data = 8'h00;
    endtask

    // 0 token, 1 tx_done, 2 rx_done, 3 ack
    task automatic pulse(input int which);
        @(negedge clk);
        case (which)
            0: token_in = 1'b1;
            1: tx_done = 1'b1;
            2: rx_done = 1'b1;
            default: ack_in = 1'b1;
        endcase
        @(negedge clk);
        token_in = 1'b0; tx_done = 1'b0; rx_done = 1'b0; ack_in = 1'b0;
    endtask

    function automatic int base_of(input logic [7:0] c);
        return int'(c[4:3]) * 512 + int'(c[5]) * 256;
    endfunction

    initial begin
        do_reset();
        // R1 reset state
        chk("R1 tx_avail", tx_avail, 1);
        chk("R1 tx_acked", tx_acked, 0);
        chk("R1 rx_inhib", rx_inhib, 1);
        chk("R1 rx_en", rx_en, 0);
        chk("R1 rx_bcast", rx_bcast, 0);
        chk("R1 tx_req", tx_req, 0);
        chk("R1 tx_base", int'(tx_base), 0);
        chk("R1 rx_base", int'(rx_base), 0);

        // exhaustive sweep: R2 R5 R9 R10
        for (int k = 0; k < 256; k++) begin
            logic [7:0] c;
            bit is_tx, is_rx;
            c = 8'(k);
            is_tx = (c[7:6] == 2'b00) && (c[2:0] == 3'b011);
            is_rx = (c[6] == 1'b0) && (c[2:0] == 3'b100);
            do_reset();
            wrc(c);
            chk("R2 tx_avail after write", tx_avail, is_tx ? 0 : 1);
            chk("R2 tx_acked after write", tx_acked, 0);
            chk("R2 tx_req waits token", tx_req, 0);
            chk("R9 tx_base", int'(tx_base), is_tx ? base_of(c) : 0);
            chk("R5 rx_en", rx_en, is_rx ? 1 : 0);
            chk("R5 rx_inhib", rx_inhib, is_rx ? 0 : 1);
            chk("R5 rx_bcast", rx_bcast, (is_rx && c[7]) ? 1 : 0);
            chk("R9 rx_base", int'(rx_base), is_rx ? base_of(c) : 0);
            pulse(0);
            chk("R2 tx_req after token", tx_req, is_tx ? 1 : 0);
            chk("R10 tx_avail after token", tx_avail, is_tx ? 0 : 1);
            chk("R10 rx_inhib after token", rx_inhib, is_rx ? 0 : 1);
        end

        // R3 transmission with ACK, then without
        do_reset();
        wrc(8'b0010_1011);
        pulse(0);
        chk("R3 started", tx_req, 1);
        pulse(3);
        chk("R3 acked waits done", tx_avail, 0);
        pulse(1);
        chk("R3 avail after done", tx_avail, 1);
        chk("R3 acked with ack", tx_acked, 1);
        chk("R3 req drops", tx_req, 0);
        wrc(8'b0001_0011);
        chk("R2 acked cleared", tx_acked, 0);
        pulse(3);
        pulse(0);
        pulse(1);
        chk("R3 acked without ack in flight", tx_acked, 0);
        chk("R3 avail second", tx_avail, 1);

        // R4 cancel before start
        do_reset();
        wrc(8'b0000_1011);
        wrc(8'h01);
        chk("R4 no change before token", tx_avail, 0);
        pulse(0);
        chk("R4 avail at token", tx_avail, 1);
        chk("R4 not started", tx_req, 0);
        pulse(0);
        chk("R4 stays dropped", tx_req, 0);

        // R11 cancel after start
        do_reset();
        wrc(8'b0000_0011);
        pulse(0);
        wrc(8'h01);
        pulse(0);
        chk("R11 still sending", tx_req, 1);
        chk("R11 avail still 0", tx_avail, 0);
        pulse(1);
        chk("R11 done frees", tx_avail, 1);

        // R6 reception completes
        do_reset();
        wrc(8'b1011_1100);
        pulse(2);
        chk("R6 inhib", rx_inhib, 1);
        chk("R6 rx_en", rx_en, 0);

        // R7 cancel with line idle
        do_reset();
        wrc(8'b0000_0100);
        wrc(8'h02);
        chk("R7 no change before token", rx_en, 1);
        pulse(0);
        chk("R7 inhib at token", rx_inhib, 1);
        chk("R7 rx_en off", rx_en, 0);

        // R8 cancel during reception
        do_reset();
        wrc(8'b0000_1100);
        wrc(8'h02);
        @(negedge clk);
        rx_active = 1'b1;
        pulse(0);
        chk("R8 reception kept", rx_en, 1);
        pulse(2);
        @(negedge clk);
        rx_active = 1'b0;
        chk("R8 done inhibits", rx_inhib, 1);

        // R10 reserved code with armed state
        do_reset();
        wrc(8'b1010_0100);
        wrc(8'h00);
        chk("R10 rx_base kept", int'(rx_base), 256);
        chk("R10 rx_bcast kept", rx_bcast, 1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule